// File: doc/BRIEF.md
# Shift-Register Counter Video Timing Generator

This block produces the raster timing for one video mode: horizontal sync, vertical sync, a display-enable window, and strobes that mark the last pixel of a line and the last pixel of a frame. The horizontal and vertical position counters are not binary counters. Each one is a 16-bit linear feedback shift register that restarts from the all-ones state. A shift register has a far shallower next-state path than a binary incrementer, so the counters stay fast at wide widths.

Software programs every timing threshold as an encoded state. To get the threshold for a count N, start from all-ones and step the register N times; the state reached is the value to program. The block compares each threshold with the live counter state for equality and never treats it as a magnitude. The horizontal counter advances once for each pixel-clock enable. The vertical counter advances once at the end of each line. Each sync or window output is a set/clear flag that switches on when its start state is seen and switches off when its stop state is seen.

Top module: `vtg_lfsr_timing`

## Requirements
- R1: Reset loads both counters with the all-ones state (count 0) and clears every held flag. The outputs after reset are those for count 0 on both axes, with no region entered earlier.
- R2: Each enabled pixel moves the horizontal counter one step. A step shifts the state left by one bit and puts into bit 0 the XOR of state bits 15, 4, 2 and 1. Every threshold is compared for equality with the state reached after its count.
- R3: `eol_o` is high while the horizontal state equals the end threshold. On the next enabled pixel the counter reloads all-ones, so a line lasts end count + 1 pixels.
- R4: The vertical counter steps only on an enabled pixel that also has `eol_o` high, and holds at all other times. It reloads all-ones after the line in which it equals its end threshold. `eof_o` is high exactly when `eol_o` is high and the vertical state equals its end threshold.
- R5: When `pix_en` is low, no counter or flag changes and every output keeps its value.
- R6: `hsync_o` is high for horizontal counts c with start <= c < stop. The stop match wins on the same count. A region whose start lies after its stop spans the line wrap.
- R7: `vsync_o` follows the same start/stop rule as R6, using vertical counts and updating once per line.
- R8: `de_o` is the AND of the horizontal active window and the vertical active window. Each window follows the same start/stop rule as R6 on its own axis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable; one pixel per enabled cycle |
| h_end_st | input | 16 | Encoded horizontal end count |
| h_sync_on_st | input | 16 | Encoded horizontal sync start |
| h_sync_off_st | input | 16 | Encoded horizontal sync stop |
| h_act_on_st | input | 16 | Encoded horizontal active start |
| h_act_off_st | input | 16 | Encoded horizontal active stop |
| v_end_st | input | 16 | Encoded vertical end count |
| v_sync_on_st | input | 16 | Encoded vertical sync start |
| v_sync_off_st | input | 16 | Encoded vertical sync stop |
| v_act_on_st | input | 16 | Encoded vertical active start |
| v_act_off_st | input | 16 | Encoded vertical active stop |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| eol_o | output | 1 | Last pixel of line |
| eof_o | output | 1 | Last pixel of frame |

## Verification
The assertions check the structural timing on every cycle:
- the seed after reset;
- the shift relation between successive horizontal states;
- the reload at line end;
- the vertical counter holding between line ends;
- every state holding while `pix_en` is low;
- `eof_o` occurring only inside `eol_o`.

The exact positions of the sync and active edges, wrap-straddling regions and equal start/stop thresholds show up only in the bench scenarios. There, a model of integer counts runs against the design through several programmed modes with a gapped pixel enable.

// File: rtl/vtg_lfsr_pkg.sv
`timescale 1ns/1ps
package vtg_lfsr_pkg;
   // index of each set/clear region flag inside the top
   typedef enum int {
      RG_HSYNC = 0,
      RG_HACT  = 1,
      RG_VSYNC = 2,
      RG_VACT  = 3
   } region_e;
   localparam int NUM_REGIONS = 4;
   localparam int NUM_H_REGIONS = 2;
endpackage

// File: rtl/vtg_lfsr_counter.sv
`timescale 1ns/1ps
module vtg_lfsr_counter #(
   parameter int             W    = 16,
   parameter logic [W-1:0]   TAPS = 16'h8016
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step_en,
   input  logic [W-1:0] end_st,
   output logic [W-1:0] state_o,
   output logic         at_end_o
);
   localparam logic [W-1:0] SEED = '1;

   logic [W-1:0] state_q;
   logic         fb;

   assign fb       = ^(state_q & TAPS);
   assign at_end_o = (state_q == end_st);
   assign state_o  = state_q;

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= SEED;
      else if (step_en)
         state_q <= at_end_o ? SEED : {state_q[W-2:0], fb};
   end
endmodule

// File: rtl/vtg_span_flag.sv
`timescale 1ns/1ps
module vtg_span_flag #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         upd_en,
   input  logic [W-1:0] state,
   input  logic [W-1:0] on_st,
   input  logic [W-1:0] off_st,
   output logic         active_o
);
   logic held_q;
   logic hit_on;
   logic hit_off;

   assign hit_on   = (state == on_st);
   assign hit_off  = (state == off_st);
   // stop match has priority over start match
   assign active_o = (hit_on | held_q) & ~hit_off;

   always_ff @(posedge clk) begin
      if (rst)
         held_q <= 1'b0;
      else if (upd_en)
         held_q <= active_o;
   end
endmodule

// File: rtl/vtg_lfsr_timing.sv
`timescale 1ns/1ps
module vtg_lfsr_timing #(
   parameter int           W    = 16,
   parameter logic [W-1:0] TAPS = 16'h8016
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         pix_en,
   input  logic [W-1:0] h_end_st,
   input  logic [W-1:0] h_sync_on_st,
   input  logic [W-1:0] h_sync_off_st,
   input  logic [W-1:0] h_act_on_st,
   input  logic [W-1:0] h_act_off_st,
   input  logic [W-1:0] v_end_st,
   input  logic [W-1:0] v_sync_on_st,
   input  logic [W-1:0] v_sync_off_st,
   input  logic [W-1:0] v_act_on_st,
   input  logic [W-1:0] v_act_off_st,
   output logic         hsync_o,
   output logic         vsync_o,
   output logic         de_o,
   output logic         eol_o,
   output logic         eof_o
);
   import vtg_lfsr_pkg::*;

   generate
      if (W < 4) begin : g_bad_width
         $error("vtg_lfsr_timing: W must be at least 4");
      end
      if (!TAPS[W-1]) begin : g_bad_taps
         $error("vtg_lfsr_timing: TAPS must include the top bit");
      end
   endgenerate

   logic [W-1:0] h_state;
   logic [W-1:0] v_state;
   logic         h_at_end;
   logic         v_at_end;
   logic         v_step;

   assign v_step = pix_en & h_at_end;

   vtg_lfsr_counter #(.W(W), .TAPS(TAPS)) u_hcnt (
      .clk(clk), .rst(rst), .step_en(pix_en), .end_st(h_end_st),
      .state_o(h_state), .at_end_o(h_at_end)
   );

   vtg_lfsr_counter #(.W(W), .TAPS(TAPS)) u_vcnt (
      .clk(clk), .rst(rst), .step_en(v_step), .end_st(v_end_st),
      .state_o(v_state), .at_end_o(v_at_end)
   );

   logic [W-1:0] rg_on  [NUM_REGIONS];
   logic [W-1:0] rg_off [NUM_REGIONS];
   logic [NUM_REGIONS-1:0] rg_act;

   assign rg_on[RG_HSYNC]  = h_sync_on_st;
   assign rg_off[RG_HSYNC] = h_sync_off_st;
   assign rg_on[RG_HACT]   = h_act_on_st;
   assign rg_off[RG_HACT]  = h_act_off_st;
   assign rg_on[RG_VSYNC]  = v_sync_on_st;
   assign rg_off[RG_VSYNC] = v_sync_off_st;
   assign rg_on[RG_VACT]   = v_act_on_st;
   assign rg_off[RG_VACT]  = v_act_off_st;

   generate
      for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
         if (i < NUM_H_REGIONS) begin : g_h
            vtg_span_flag #(.W(W)) u_flag (
               .clk(clk), .rst(rst), .upd_en(pix_en), .state(h_state),
               .on_st(rg_on[i]), .off_st(rg_off[i]), .active_o(rg_act[i])
            );
         end else begin : g_v
            vtg_span_flag #(.W(W)) u_flag (
               .clk(clk), .rst(rst), .upd_en(v_step), .state(v_state),
               .on_st(rg_on[i]), .off_st(rg_off[i]), .active_o(rg_act[i])
            );
         end
      end
   endgenerate

   assign hsync_o = rg_act[RG_HSYNC];
   assign vsync_o = rg_act[RG_VSYNC];
   assign de_o    = rg_act[RG_HACT] & rg_act[RG_VACT];
   assign eol_o   = h_at_end;
   assign eof_o   = h_at_end & v_at_end;
endmodule

// File: rtl/vtg_lfsr_timing_chk.sv
`timescale 1ns/1ps
module vtg_lfsr_timing_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst,
   input logic         pix_en,
   input logic         eol_o,
   input logic         eof_o,
   input logic [W-1:0] h_state,
   input logic [W-1:0] v_state
);
   AST_RESET_SEED: assert property (@(posedge clk)
      rst |=> (h_state == '1) && (v_state == '1)); // R1

   AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
      pix_en && !eol_o |=> h_state[W-1:1] == $past(h_state[W-2:0])); // R2

   AST_LINE_RELOAD: assert property (@(posedge clk) disable iff (rst)
      pix_en && eol_o |=> h_state == '1); // R3

   AST_V_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(pix_en && eol_o) |=> $stable(v_state)); // R4

   AST_EOF_IN_EOL: assert property (@(posedge clk) disable iff (rst)
      eof_o |-> eol_o); // R4

   AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !pix_en |=> $stable(h_state)); // R5
endmodule

bind vtg_lfsr_timing vtg_lfsr_timing_chk #(.W(W)) u_chk (
   .clk(clk), .rst(rst), .pix_en(pix_en), .eol_o(eol_o), .eof_o(eof_o),
   .h_state(h_state), .v_state(v_state)
);

// File: tb/vtg_lfsr_timing_tb.sv
`timescale 1ns/1ps
module vtg_lfsr_timing_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pix_en = 1'b0;
   logic [15:0] h_end_st, h_sync_on_st, h_sync_off_st, h_act_on_st, h_act_off_st;
   logic [15:0] v_end_st, v_sync_on_st, v_sync_off_st, v_act_on_st, v_act_off_st;
   logic hsync_o, vsync_o, de_o, eol_o, eof_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vtg_lfsr_timing u_dut (
      .clk(clk), .rst(rst), .pix_en(pix_en),
      .h_end_st(h_end_st), .h_sync_on_st(h_sync_on_st), .h_sync_off_st(h_sync_off_st),
      .h_act_on_st(h_act_on_st), .h_act_off_st(h_act_off_st),
      .v_end_st(v_end_st), .v_sync_on_st(v_sync_on_st), .v_sync_off_st(v_sync_off_st),
      .v_act_on_st(v_act_on_st), .v_act_off_st(v_act_off_st),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .eol_o(eol_o), .eof_o(eof_o)
   );

   // encoded state after n steps from all-ones
   function automatic logic [15:0] enc(int n);
      logic [15:0] s = 16'hFFFF;
      for (int k = 0; k < n; k++)
         s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
      return s;
   endfunction

   // model: binary counts and region memories
   int hend, hson, hsoff, haon, haoff, vend, vson, vsoff, vaon, vaoff;
   int hc, vc;
   bit m_hs, m_ha, m_vs, m_va;

   function automatic bit inreg(int c, int on, int off, bit mem);
      return (c == on || mem) && c != off;
   endfunction

   task automatic chk(bit act, bit exp, string req, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s at h=%0d v=%0d: actual %0b expected %0b", req, what, hc, vc, act, exp);
      end
   endtask

   task automatic compare_all(string req_sync);
      bit ha, va;
      ha = inreg(hc, haon, haoff, m_ha);
      va = inreg(vc, vaon, vaoff, m_va);
      chk(hsync_o, inreg(hc, hson, hsoff, m_hs), "R6", "hsync");
      chk(vsync_o, inreg(vc, vson, vsoff, m_vs), "R7", "vsync");
      chk(de_o, ha && va, "R8", "de");
      chk(eol_o, hc == hend, "R3", "eol");
      chk(eof_o, hc == hend && vc == vend, "R4", "eof");
      if (req_sync != "") chk(1'b1, 1'b1, req_sync, "tag");
   endtask

   task automatic model_step();
      bit le;
      le = (hc == hend);
      m_hs = inreg(hc, hson, hsoff, m_hs);
      m_ha = inreg(hc, haon, haoff, m_ha);
      if (le) begin
         m_vs = inreg(vc, vson, vsoff, m_vs);
         m_va = inreg(vc, vaon, vaoff, m_va);
         vc = (vc == vend) ? 0 : vc + 1;
      end
      hc = le ? 0 : hc + 1;
   endtask

   task automatic run_mode(int a_hend, int a_hson, int a_hsoff, int a_haon, int a_haoff,
                           int a_vend, int a_vson, int a_vsoff, int a_vaon, int a_vaoff,
                           int ncyc, int gap);
      hend = a_hend; hson = a_hson; hsoff = a_hsoff; haon = a_haon; haoff = a_haoff;
      vend = a_vend; vson = a_vson; vsoff = a_vsoff; vaon = a_vaon; vaoff = a_vaoff;
      @(negedge clk);
      rst = 1'b1; pix_en = 1'b0;
      h_end_st = enc(hend); h_sync_on_st = enc(hson); h_sync_off_st = enc(hsoff);
      h_act_on_st = enc(haon); h_act_off_st = enc(haoff);
      v_end_st = enc(vend); v_sync_on_st = enc(vson); v_sync_off_st = enc(vsoff);
      v_act_on_st = enc(vaon); v_act_off_st = enc(vaoff);
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
      hc = 0; vc = 0; m_hs = 0; m_ha = 0; m_vs = 0; m_va = 0;
      compare_all("R1"); // reset state
      for (int cyc = 0; cyc < ncyc; cyc++) begin
         bit en;
         en = (gap == 0) ? 1'b1 : ((cyc % gap) != gap - 1);
         pix_en = en;
         @(posedge clk);
         if (en) model_step();
         @(negedge clk);
         // R2: correct counts imply correct LFSR stepping; R5 when en is low
         compare_all(en ? "R2" : "R5");
      end
      pix_en = 1'b0;
   endtask

   initial begin
      h_end_st = '0; h_sync_on_st = '0; h_sync_off_st = '0; h_act_on_st = '0; h_act_off_st = '0;
      v_end_st = '0; v_sync_on_st = '0; v_sync_off_st = '0; v_act_on_st = '0; v_act_off_st = '0;
      repeat (3) @(posedge clk);
      // ordinary mode: 20-pixel lines, 10-line frames, gapped enable
      run_mode(19, 1, 4, 3, 15, 9, 0, 2, 2, 8, 700, 4);
      // regions straddling the wrap on both axes, full-rate enable
      run_mode(15, 13, 2, 10, 3, 6, 5, 1, 4, 2, 400, 0);
      // equal start and stop: region never opens; long pauses
      run_mode(11, 5, 5, 0, 11, 4, 3, 3, 0, 4, 500, 3);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule